// File: doc/BRIEF.md
# USB Endpoint Handshake State Controller

This block holds the per-endpoint bookkeeping that a USB device function needs to answer the host: a buffer-full flag, a stall flag and a data-toggle bit for each of six endpoints. The packet memory and the serial engine live elsewhere. Only the flags are kept here. Endpoint indices are physical: an even index is an OUT (host-to-device) endpoint and an odd index is an IN endpoint. Indices 0 and 1 form the control pair.

A microcontroller drives the block through a byte-wide port with two strobes: a command write and a data write. The command set covers endpoint selection, freeing an OUT buffer, arming an IN buffer, writing an endpoint's status byte, and acknowledging a setup packet.

The USB engine reports events to the block: a SETUP packet, an IN token, a completed OUT data packet with its received PID, and an IN transfer acknowledged by the host. One cycle after each event, the block answers with a handshake decision (ACK, NAK or STALL). For an IN token it also gives the DATA PID to send.

Top module: `usb_ep_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all full, stall and toggle flags are cleared, the setup lock is cleared, the selected endpoint becomes 0 and `hs_valid` is 0.
- R2: Command bytes 0x00 to 0x05 select endpoint 0 to 5, and `sel_ep` shows the choice from the next cycle on. Even indices are OUT endpoints, odd indices are IN endpoints, and 0 and 1 are the control pair.
- R3: An OUT data event (`ev_kind`=2) on an even endpoint that is neither stalled nor full is answered with ACK (`hs_code`=1). If `ev_pid1` equals the endpoint's toggle, the full flag sets and the toggle flips. If it does not match, nothing changes.
- R4: An OUT data event on a full, unstalled OUT endpoint is answered with NAK (`hs_code`=2), and the endpoint's flags are left unchanged.
- R5: Command 0xF2 clears the full flag of the selected endpoint when that endpoint is an OUT endpoint. When the selected endpoint is an IN endpoint, the command has no effect.
- R6: Command 0xFA sets the full flag of the selected endpoint when that endpoint is an IN endpoint. When the selected endpoint is an OUT endpoint, the command has no effect.
- R7: An IN token (`ev_kind`=1) on an odd endpoint is answered with ACK and `hs_pid1` equal to its toggle when the endpoint is full, and with NAK when it is empty. An IN-acknowledged event (`ev_kind`=3) on a full, unstalled IN endpoint clears its full flag and flips its toggle.
- R8: Command 0x40+n followed by a data write with bit 0 set stalls endpoint n. A stalled endpoint answers IN tokens and OUT data with STALL (`hs_code`=3), even when its buffer is full.
- R9: A status data byte with bit 0 clear re-initializes the armed endpoint: stall, full and toggle all become 0, whether or not it was stalled. A data write with no armed status command is ignored. Any command write disarms a pending status command.
- R10: A SETUP event (`ev_kind`=0) on endpoint 0 is always answered with ACK. It clears the stall flags of endpoints 0 and 1, sets the full flag of endpoint 0, clears the full flag of endpoint 1, sets both toggles to DATA1 and sets `setup_lock`.
- R11: While `setup_lock` is 1, commands 0xF2 and 0xFA are ignored when endpoint 0 or 1 is selected. Command 0xF1 clears the lock only when endpoint 0 or 1 is selected.
- R12: Undefined command bytes (for example 0x06, 0x46, 0x80, 0xF0) change no flag, no selection and no lock, and they arm no status write.
- R13: `hs_valid` is high for exactly one cycle, the cycle after an event that is answered. Only these events are answered: SETUP on endpoint 0, IN tokens on IN endpoints and OUT data on OUT endpoints. Events with the wrong direction or an index of 6 or more get no answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Strobe: `bus_byte` is a command |
| dat_wr | input | 1 | Strobe: `bus_byte` is a data byte |
| bus_byte | input | 8 | Microcontroller byte |
| ev_valid | input | 1 | USB event strobe |
| ev_kind | input | 2 | 0 SETUP, 1 IN token, 2 OUT data done, 3 IN acknowledged |
| ev_ep | input | 3 | Physical endpoint index of the event |
| ev_pid1 | input | 1 | Received PID is DATA1 (OUT data only) |
| hs_valid | output | 1 | Handshake decision present |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| hs_pid1 | output | 1 | DATA PID to send on an IN ACK (1 = DATA1) |
| ep_full | output | 6 | Buffer-full flag per endpoint |
| ep_stall | output | 6 | Stall flag per endpoint |
| ep_toggle | output | 6 | Data toggle per endpoint |
| setup_lock | output | 1 | Setup received and not yet acknowledged |
| sel_ep | output | 3 | Currently selected endpoint |

## Verification
The bench builds the block with its default of six endpoints. With six endpoints the index field is three bits wide, so indices 6 and 7 can be driven and the out-of-range rejection gets exercised. Six endpoints also cover both control slots and both directions of the non-control pairs. With this width the status code range 0x40 to 0x45 has a real undefined neighbour at 0x46, which shows that the decoder bounds the range by the parameter.

// File: rtl/usb_ep_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the endpoint handshake controller.
// Assumes: command byte values are fixed by the firmware interface.
package usb_ep_pkg;
    typedef enum logic [1:0] {
        EV_SETUP = 2'd0,
        EV_IN    = 2'd1,
        EV_OUT   = 2'd2,
        EV_INACK = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

    localparam logic [7:0] CMD_STAT_BASE = 8'h40;
    localparam logic [7:0] CMD_ACK_SETUP = 8'hF1;
    localparam logic [7:0] CMD_CLR_BUF   = 8'hF2;
    localparam logic [7:0] CMD_VAL_BUF   = 8'hFA;
endpackage

// File: rtl/usb_ep_cmd_dec.sv
`timescale 1ns/1ps
// Module: command decoder. Holds the selected endpoint, the armed status
// write and the setup lock, and turns command/data writes into one-hot
// per-endpoint strobes.
// Assumes: cmd_wr takes priority over dat_wr in the same cycle; endpoint
// direction comes from index bit 0 (odd = IN); indices 0 and 1 are control.
module usb_ep_cmd_dec
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [7:0]        bus_byte,
    input  logic              setup_ev,
    output logic [EP_W-1:0]   sel_ep,
    output logic              lock,
    output logic [NUM_EP-1:0] clr_v,
    output logic [NUM_EP-1:0] val_v,
    output logic [NUM_EP-1:0] stall_v,
    output logic [NUM_EP-1:0] reinit_v
);
    logic [EP_W-1:0] sel_q, pend_ep_q, stat_ep;
    logic [7:0]      stat_off;
    logic            pend_q, lock_q;
    logic            sel_ctrl, guarded, hit_sel, hit_stat;
    logic            hit_clr, hit_val, hit_acks, st_apply, known;

    // Classify the byte on the port against the current selection and lock.
    always_comb begin
        stat_off = bus_byte - CMD_STAT_BASE;
        stat_ep  = stat_off[EP_W-1:0];
        sel_ctrl = (int'(sel_q) < 2);
        guarded  = lock_q && sel_ctrl;
        hit_sel  = cmd_wr && (int'(bus_byte) < NUM_EP);
        hit_stat = cmd_wr && (bus_byte >= CMD_STAT_BASE)
                   && (int'(stat_off) < NUM_EP);
        hit_clr  = cmd_wr && (bus_byte == CMD_CLR_BUF) && !sel_q[0] && !guarded;
        hit_val  = cmd_wr && (bus_byte == CMD_VAL_BUF) && sel_q[0] && !guarded;
        hit_acks = cmd_wr && (bus_byte == CMD_ACK_SETUP) && sel_ctrl;
        st_apply = dat_wr && !cmd_wr && pend_q;
        known    = hit_sel || hit_stat || (bus_byte == CMD_ACK_SETUP)
                   || (bus_byte == CMD_CLR_BUF) || (bus_byte == CMD_VAL_BUF);
    end

    // Fan the decoded command out to one strobe per endpoint.
    for (genvar i = 0; i < NUM_EP; i++) begin : g_strobe
        assign clr_v[i]    = hit_clr && (sel_q == EP_W'(i));
        assign val_v[i]    = hit_val && (sel_q == EP_W'(i));
        assign stall_v[i]  = st_apply && (pend_ep_q == EP_W'(i)) && bus_byte[0];
        assign reinit_v[i] = st_apply && (pend_ep_q == EP_W'(i)) && !bus_byte[0];
    end

    // Track selection, the armed status write and the setup lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            pend_q    <= 1'b0;
            pend_ep_q <= '0;
            lock_q    <= 1'b0;
        end else begin
            if (hit_sel) sel_q <= bus_byte[EP_W-1:0];
            if (cmd_wr) begin
                pend_q <= hit_stat;
                if (hit_stat) pend_ep_q <= stat_ep;
            end else if (st_apply) begin
                pend_q <= 1'b0;
            end
            if (setup_ev)      lock_q <= 1'b1;
            else if (hit_acks) lock_q <= 1'b0;
        end
    end

    assign sel_ep = sel_q;
    assign lock   = lock_q;

    // R12
    undef_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !known && !setup_ev) |=> ($stable(sel_q) && $stable(lock_q) && !pend_q));
endmodule

// File: rtl/usb_ep_slot.sv
`timescale 1ns/1ps
// Module: one endpoint's flags (full, stall, toggle).
// Assumes: strobes arrive already filtered by direction and lock; events
// are applied after commands, so a SETUP in the same cycle wins.
module usb_ep_slot #(
    parameter bit IS_IN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic val,
    input  logic stall_set,
    input  logic reinit,
    input  logic setup_hit,
    input  logic out_take,
    input  logic in_ack,
    output logic full,
    output logic stall,
    output logic tog
);
    logic full_q, stall_q, tog_q;
    logic full_d, stall_d, tog_d;

    // Next flag values: commands first, then USB events on top.
    always_comb begin
        full_d  = full_q;
        stall_d = stall_q;
        tog_d   = tog_q;
        if (reinit) begin
            full_d  = 1'b0;
            stall_d = 1'b0;
            tog_d   = 1'b0;
        end
        if (stall_set) stall_d = 1'b1;
        if (clr)       full_d  = 1'b0;
        if (val)       full_d  = 1'b1;
        if (setup_hit) begin
            stall_d = 1'b0;
            tog_d   = 1'b1;
            full_d  = !IS_IN;
        end
        if (out_take) begin
            full_d = 1'b1;
            tog_d  = ~tog_q;
        end
        if (in_ack) begin
            full_d = 1'b0;
            tog_d  = ~tog_q;
        end
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            stall_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            full_q  <= full_d;
            stall_q <= stall_d;
            tog_q   <= tog_d;
        end
    end

    assign full  = full_q;
    assign stall = stall_q;
    assign tog   = tog_q;

    // R9
    reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && !setup_hit && !out_take && !in_ack) |=> (!full_q && !stall_q && !tog_q));

    if (!IS_IN) begin : g_out_hold
        // R4
        full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (full_q && !clr && !reinit && !setup_hit) |=> full_q);
    end
endmodule

// File: rtl/usb_ep_hs.sv
`timescale 1ns/1ps
// Module: handshake decision. Looks up the addressed endpoint's flags,
// registers ACK/NAK/STALL plus DATA PID, and emits per-endpoint event
// strobes for accepted OUT data and completed IN transfers.
// Assumes: a stall outranks full/empty; only correctly directed events
// on existing endpoints are answered.
module usb_ep_hs
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int EP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_pid1,
    input  logic [NUM_EP-1:0] full_v,
    input  logic [NUM_EP-1:0] stall_v,
    input  logic [NUM_EP-1:0] tog_v,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              hs_pid1,
    output logic              setup_ev,
    output logic [NUM_EP-1:0] out_take_v,
    output logic [NUM_EP-1:0] in_ack_v
);
    ev_kind_e        kind;
    logic [EP_W-1:0] idx;
    logic            ep_ok, fl, st, tg, in_tok, out_pkt, in_done, take;
    hs_code_e        code_d;
    logic            pid_d;
    logic [NUM_EP-1:0] one_hot;

    // Decode the event and pick the answer from the addressed flags.
    always_comb begin
        kind     = ev_kind_e'(ev_kind);
        ep_ok    = int'(ev_ep) < NUM_EP;
        idx      = ep_ok ? ev_ep : '0;
        fl       = full_v[idx];
        st       = stall_v[idx];
        tg       = tog_v[idx];
        one_hot  = NUM_EP'(1) << idx;
        setup_ev = ev_valid && (kind == EV_SETUP) && (ev_ep == '0);
        in_tok   = ev_valid && (kind == EV_IN) && ep_ok && ev_ep[0];
        out_pkt  = ev_valid && (kind == EV_OUT) && ep_ok && !ev_ep[0];
        in_done  = ev_valid && (kind == EV_INACK) && ep_ok && ev_ep[0] && fl && !st;
        take     = out_pkt && !st && !fl && (ev_pid1 == tg);
        out_take_v = take ? one_hot : '0;
        in_ack_v   = in_done ? one_hot : '0;
        code_d = HS_NONE;
        pid_d  = 1'b0;
        if (setup_ev) begin
            code_d = HS_ACK;
        end else if (in_tok) begin
            if (st)      code_d = HS_STALL;
            else if (fl) begin
                code_d = HS_ACK;
                pid_d  = tg;
            end else     code_d = HS_NAK;
        end else if (out_pkt) begin
            if (st)      code_d = HS_STALL;
            else if (fl) code_d = HS_NAK;
            else         code_d = HS_ACK;
        end
    end

    // Register the handshake so it appears one cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            hs_pid1  <= 1'b0;
        end else begin
            hs_valid <= (code_d != HS_NONE);
            hs_code  <= code_d;
            hs_pid1  <= pid_d;
        end
    end

    // R8
    stall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_tok || out_pkt) && st) |=> (hs_valid && hs_code == HS_STALL));
    // R4
    full_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pkt && fl && !st) |=> (hs_valid && hs_code == HS_NAK));
    // R13
    hs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code != HS_NONE));
endmodule

// File: rtl/usb_ep_ctrl.sv
`timescale 1ns/1ps
// Module: top of the endpoint handshake controller. Connects the command
// decoder, the handshake decision and one flag slot per endpoint.
// Assumes: physical endpoint index, even = OUT, odd = IN, 0/1 = control.
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter  int NUM_EP = 6,
    localparam int EP_W   = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [7:0]        bus_byte,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_pid1,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              hs_pid1,
    output logic [NUM_EP-1:0] ep_full,
    output logic [NUM_EP-1:0] ep_stall,
    output logic [NUM_EP-1:0] ep_toggle,
    output logic              setup_lock,
    output logic [EP_W-1:0]   sel_ep
);
    logic [NUM_EP-1:0] clr_v, val_v, stall_v, reinit_v, out_take_v, in_ack_v;
    logic              setup_ev;

    usb_ep_cmd_dec #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .bus_byte(bus_byte), .setup_ev(setup_ev), .sel_ep(sel_ep),
        .lock(setup_lock), .clr_v(clr_v), .val_v(val_v),
        .stall_v(stall_v), .reinit_v(reinit_v)
    );

    usb_ep_hs #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_hs (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_ep(ev_ep), .ev_pid1(ev_pid1), .full_v(ep_full),
        .stall_v(ep_stall), .tog_v(ep_toggle), .hs_valid(hs_valid),
        .hs_code(hs_code), .hs_pid1(hs_pid1), .setup_ev(setup_ev),
        .out_take_v(out_take_v), .in_ack_v(in_ack_v)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
        localparam bit IS_CTRL = (i < 2);
        usb_ep_slot #(.IS_IN(i % 2 == 1)) u_slot (
            .clk(clk), .rst_n(rst_n), .clr(clr_v[i]), .val(val_v[i]),
            .stall_set(stall_v[i]), .reinit(reinit_v[i]),
            .setup_hit(IS_CTRL ? setup_ev : 1'b0),
            .out_take(out_take_v[i]), .in_ack(in_ack_v[i]),
            .full(ep_full[i]), .stall(ep_stall[i]), .tog(ep_toggle[i])
        );
    end

    // R10
    setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ev |=> (!ep_stall[0] && !ep_stall[1] && ep_full[0] && !ep_full[1]
                      && ep_toggle[0] && ep_toggle[1] && setup_lock));
endmodule

// File: tb/usb_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_ep_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, cmd_wr, dat_wr, ev_valid, ev_pid1;
    logic [7:0] bus_byte;
    logic [1:0] ev_kind;
    logic [2:0] ev_ep;
    logic       hs_valid, hs_pid1, setup_lock;
    logic [1:0] hs_code;
    logic [5:0] ep_full, ep_stall, ep_toggle;
    logic [2:0] sel_ep;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_ep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .bus_byte(bus_byte), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_ep(ev_ep), .ev_pid1(ev_pid1), .hs_valid(hs_valid),
        .hs_code(hs_code), .hs_pid1(hs_pid1), .ep_full(ep_full),
        .ep_stall(ep_stall), .ep_toggle(ep_toggle),
        .setup_lock(setup_lock), .sel_ep(sel_ep)
    );

    // op 0 cmd, 1 data, 2 event (val = kind<<3 | ep); then pid, expected
    // {hs_valid, hs_code, hs_pid1, full, stall, toggle, lock}
    localparam int NV = 42;
    localparam logic [33:0] VEC [NV] = '{
        {2'd2,8'h12,1'b0, 1'b1,2'd1,1'b0, 6'b000100,6'b000000,6'b000100,1'b0}, // R3 accept
        {2'd2,8'h12,1'b1, 1'b1,2'd2,1'b0, 6'b000100,6'b000000,6'b000100,1'b0}, // R4 nak
        {2'd0,8'h02,1'b0, 1'b0,2'd0,1'b0, 6'b000100,6'b000000,6'b000100,1'b0}, // R2
        {2'd0,8'hF2,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000100,1'b0}, // R5
        {2'd2,8'h12,1'b0, 1'b1,2'd1,1'b0, 6'b000000,6'b000000,6'b000100,1'b0}, // R3 mismatch
        {2'd2,8'h12,1'b1, 1'b1,2'd1,1'b0, 6'b000100,6'b000000,6'b000000,1'b0}, // R3
        {2'd0,8'h03,1'b0, 1'b0,2'd0,1'b0, 6'b000100,6'b000000,6'b000000,1'b0}, // R2
        {2'd2,8'h0B,1'b0, 1'b1,2'd2,1'b0, 6'b000100,6'b000000,6'b000000,1'b0}, // R7 nak
        {2'd0,8'hFA,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b000000,6'b000000,1'b0}, // R6
        {2'd2,8'h0B,1'b0, 1'b1,2'd1,1'b0, 6'b001100,6'b000000,6'b000000,1'b0}, // R7 data0
        {2'd2,8'h1B,1'b0, 1'b0,2'd0,1'b0, 6'b000100,6'b000000,6'b001000,1'b0}, // R7 done
        {2'd0,8'hFA,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b000000,6'b001000,1'b0}, // R6
        {2'd2,8'h0B,1'b0, 1'b1,2'd1,1'b1, 6'b001100,6'b000000,6'b001000,1'b0}, // R7 data1
        {2'd0,8'h43,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b000000,6'b001000,1'b0}, // R8
        {2'd1,8'h01,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b001000,6'b001000,1'b0}, // R8
        {2'd2,8'h0B,1'b0, 1'b1,2'd3,1'b0, 6'b001100,6'b001000,6'b001000,1'b0}, // R8 stall
        {2'd1,8'h00,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b001000,6'b001000,1'b0}, // R9 unarmed
        {2'd0,8'h43,1'b0, 1'b0,2'd0,1'b0, 6'b001100,6'b001000,6'b001000,1'b0}, // R9
        {2'd1,8'hFE,1'b0, 1'b0,2'd0,1'b0, 6'b000100,6'b000000,6'b000000,1'b0}, // R9 unstall
        {2'd0,8'h42,1'b0, 1'b0,2'd0,1'b0, 6'b000100,6'b000000,6'b000000,1'b0}, // R9
        {2'd1,8'h00,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000000,1'b0}, // R9 not stalled
        {2'd0,8'h40,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000000,1'b0}, // R8
        {2'd1,8'h01,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000001,6'b000000,1'b0}, // R8
        {2'd2,8'h10,1'b0, 1'b1,2'd3,1'b0, 6'b000000,6'b000001,6'b000000,1'b0}, // R8 out stall
        {2'd2,8'h00,1'b0, 1'b1,2'd1,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R10
        {2'd0,8'h00,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R2
        {2'd0,8'hF2,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R11 locked
        {2'd0,8'h04,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R2
        {2'd0,8'hF1,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R11 wrong ep
        {2'd0,8'h00,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b1}, // R2
        {2'd0,8'hF1,1'b0, 1'b0,2'd0,1'b0, 6'b000001,6'b000000,6'b000011,1'b0}, // R11 release
        {2'd0,8'hF2,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R5
        {2'd0,8'h46,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R12
        {2'd1,8'h01,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R12 not armed
        {2'd0,8'h80,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R12
        {2'd0,8'hF0,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R12
        {2'd0,8'h06,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R12
        {2'd2,8'h0A,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R13 in to out ep
        {2'd2,8'h15,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R13 out to in ep
        {2'd2,8'h02,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R13 setup ep2
        {2'd2,8'h0E,1'b0, 1'b0,2'd0,1'b0, 6'b000000,6'b000000,6'b000011,1'b0}, // R13 ep6
        {2'd2,8'h12,1'b0, 1'b1,2'd1,1'b0, 6'b000100,6'b000000,6'b000111,1'b0}  // R9 data0 after reinit
    };

    function automatic logic [22:0] snap();
        return {hs_valid, hs_code, hs_pid1, ep_full, ep_stall, ep_toggle, setup_lock};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmd_wr = 1'b0; dat_wr = 1'b0; ev_valid = 1'b0;
        bus_byte = 8'h00; ev_kind = 2'd0; ev_ep = 3'd0; ev_pid1 = 1'b0;
    endtask

    // Drive one op at a negedge; return at the next negedge with inputs idle.
    task automatic step(input logic [1:0] op, input logic [7:0] val, input logic pid);
        case (op)
            2'd0: begin cmd_wr = 1'b1; bus_byte = val; end
            2'd1: begin dat_wr = 1'b1; bus_byte = val; end
            default: begin
                ev_valid = 1'b1; ev_kind = val[4:3]; ev_ep = val[2:0]; ev_pid1 = pid;
            end
        endcase
        @(negedge clk);
        idle();
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {9'd0, snap()}, 32'd0);
        check("R1 sel", {29'd0, sel_ep}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][33:32], VEC[i][31:24], VEC[i][23]);
            check($sformatf("vector %0d", i), {9'd0, snap()}, {9'd0, VEC[i][22:0]});
        end
        // R2 selection shows on sel_ep
        step(2'd0, 8'h05, 1'b0);
        check("R2 sel", {29'd0, sel_ep}, 32'd5);
        // R12 undefined select code keeps selection
        step(2'd0, 8'h06, 1'b0);
        check("R12 sel", {29'd0, sel_ep}, 32'd5);
        // R9 a command between status code and data disarms it
        step(2'd0, 8'h41, 1'b0);
        step(2'd0, 8'h05, 1'b0);
        step(2'd1, 8'h01, 1'b0);
        check("R9 disarm", {26'd0, ep_stall}, 32'd0);
        // R13 handshake lasts one cycle
        step(2'd2, 8'h12, 1'b1);
        check("R13 pulse", {29'd0, hs_valid, hs_code}, {29'd0, 1'b1, 2'd2});
        @(negedge clk);
        check("R13 one cycle", {31'd0, hs_valid}, 32'd0);
        // R1 reset mid-run clears flags
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun", {9'd0, snap()}, 32'd0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule